// File: doc/BRIEF.md
# I2C Register Master with Mailbox Control

This block lets a host reach single registers inside devices on an external I2C bus without driving the bus itself. The host works through four 16-bit words on a simple write/read port. It first stores a register index, and for a write also the data byte, in an argument word. It then writes one command word. The upper byte of the command word selects write or read, and bits 7:1 hold the 7-bit slave address. That single command write starts the whole bus transaction.

While the transaction runs, a busy bit in the status word is set. A finished read sets a completion bit and places the received byte in a result word. A slave that does not acknowledge a byte ends the transfer early and sets a sticky error bit. Both sticky bits are cleared by writing 1 to them. SCL and SDA are open-drain, so the block only ever pulls a line low or releases it. The SCL rate comes from the system clock through a divider that the parameters set.

Top module: `i2c_mbox_master`

## Requirements
- R1: The argument word (address 1) holds the register index in bits 7:0 and the write data byte in bits 15:8, and it reads back exactly as written.
- R2: A command word (address 2) whose upper byte is 0xC4 starts a write. The bus carries START, the slave address from command bits 7:1 with R/W=0, the index, the data byte, then STOP, and the slave stores the data at that index.
- R3: A command word whose upper byte is 0xC0 starts a read. The bus carries START, address+W, the index, a repeated START, address+R, one byte returned by the slave, a master NACK, then STOP: two STARTs and one STOP per read.
- R4: Status bit 12 (address 0) reads 1 from the cycle after an accepted command until the bus is free after STOP, and reads 0 otherwise.
- R5: Status bit 14 is set when a read completes with every byte acknowledged. It stays set until a status write with bit 14 = 1 clears it; writing 0 there leaves it set.
- R6: The result word (address 3) returns the last received byte in bits 15:8 and zero in bits 7:0.
- R7: A NACK on any byte ends the transfer with STOP and clears busy. It sets status bit 13, which stays set until written with 1, and it does not set bit 14 or store data in the slave.
- R8: A command written while busy is set is ignored: the running transfer finishes unchanged and no further transfer follows.
- R9: A command word whose upper byte is neither 0xC4 nor 0xC0 is ignored: busy stays 0 and the bus stays released.
- R10: Both lines are released while idle. SDA changes only while SCL is low, except to form START and STOP. Every SCL low phase lasts 2*QDIV clocks, where QDIV = CLK_HZ/(4*SCL_HZ), and SDA is sampled as SCL rises.
- R11: The low SDA of a START or repeated START is held for at least 2*QDIV clocks with SCL high. The STOP setup (SCL high, SDA low) also lasts at least 2*QDIV clocks.
- R12: After reset all status bits, the argument word and the result word read 0, and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_wr_addr | input | 2 | Word selected for a write |
| reg_wdata | input | 16 | Host write data |
| reg_rd_addr | input | 2 | Word selected for a read |
| reg_rdata | output | 16 | Read data of the selected word |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
The bench builds the block with CLK_HZ = 8 MHz and SCL_HZ = 1 MHz, which gives a quarter period of two clocks. With that setting a full write or read takes only a few hundred cycles. Many transfers fit in a run: address and data NACKs, a command written mid-transfer and an invalid opcode. The short quarter also lets the bench measure every SCL low phase and each START and STOP hold against exact clock counts through an open-drain slave model.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // host word addresses
    localparam logic [1:0] RA_STAT = 2'd0;
    localparam logic [1:0] RA_ARG  = 2'd1;
    localparam logic [1:0] RA_CMD  = 2'd2;
    localparam logic [1:0] RA_RES  = 2'd3;

    // command opcodes (upper byte of the command word)
    localparam logic [7:0] OP_WRITE = 8'hC4;
    localparam logic [7:0] OP_READ  = 8'hC0;

    // status bit positions
    localparam int SB_BUSY = 12;
    localparam int SB_ERR  = 13;
    localparam int SB_DONE = 14;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_TX, ST_ACK, ST_RSTART,
        ST_RX, ST_MNACK, ST_STOP, ST_FREE
    } bus_st_e;

    typedef struct packed {
        bus_st_e     st;
        logic [1:0]  ph;
        logic [2:0]  bitn;
        logic [1:0]  step;
        logic        rd;
        logic [6:0]  saddr;
        logic [7:0]  idx;
        logic [7:0]  wdat;
        logic [7:0]  sh;
        logic        nack;
        logic        scl_low;
        logic        sda_low;
    } eng_s;

    typedef struct packed {
        logic [15:0] arg;
        logic [7:0]  res;
        logic        done;
        logic        err;
    } regs_s;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QDIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       go_rd,
    input  logic [6:0] go_saddr,
    input  logic [7:0] go_idx,
    input  logic [7:0] go_wdat,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       ev_rdone,
    output logic       ev_nack,
    output logic [7:0] rx_byte
);
    eng_s d, q;

    always_comb begin
        d        = q;
        ev_rdone = 1'b0;
        ev_nack  = 1'b0;
        if (q.st == ST_IDLE) begin
            if (go) begin
                d.st    = ST_START;
                d.ph    = 2'd0;
                d.bitn  = 3'd0;
                d.step  = 2'd0;
                d.rd    = go_rd;
                d.saddr = go_saddr;
                d.idx   = go_idx;
                d.wdat  = go_wdat;
                d.sh    = {go_saddr, 1'b0};
                d.nack  = 1'b0;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            // quarter 1 -> 2 is the SCL rising edge: sample SDA here
            if (q.ph == 2'd1) begin
                if (q.st == ST_ACK) d.nack = sda_in;
                if (q.st == ST_RX)  d.sh   = {q.sh[6:0], sda_in};
            end
            if (q.ph == 2'd3) begin
                case (q.st)
                    ST_START: begin
                        d.st   = ST_TX;
                        d.bitn = 3'd0;
                    end
                    ST_TX: begin
                        if (q.bitn == 3'd7) begin
                            d.st = ST_ACK;
                        end else begin
                            d.bitn = q.bitn + 3'd1;
                            d.sh   = {q.sh[6:0], 1'b0};
                        end
                    end
                    ST_ACK: begin
                        d.bitn = 3'd0;
                        if (q.nack) begin
                            d.st = ST_STOP;
                        end else begin
                            case (q.step)
                                2'd0: begin
                                    d.st   = ST_TX;
                                    d.sh   = q.idx;
                                    d.step = 2'd1;
                                end
                                2'd1: begin
                                    if (q.rd) begin
                                        d.st = ST_RSTART;
                                    end else begin
                                        d.st   = ST_TX;
                                        d.sh   = q.wdat;
                                        d.step = 2'd2;
                                    end
                                end
                                default: d.st = q.rd ? ST_RX : ST_STOP;
                            endcase
                        end
                    end
                    ST_RSTART: begin
                        d.st   = ST_START;
                        d.sh   = {q.saddr, 1'b1};
                        d.step = 2'd2;
                    end
                    ST_RX: begin
                        if (q.bitn == 3'd7) d.st = ST_MNACK;
                        else                d.bitn = q.bitn + 3'd1;
                    end
                    ST_MNACK: d.st = ST_STOP;
                    ST_STOP:  d.st = ST_FREE;
                    ST_FREE: begin
                        d.st     = ST_IDLE;
                        ev_nack  = q.nack;
                        ev_rdone = q.rd && !q.nack;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end

        // line control for the state and quarter being entered
        case (d.st)
            ST_IDLE, ST_FREE: begin
                d.scl_low = 1'b0;
                d.sda_low = 1'b0;
            end
            ST_START: begin
                d.scl_low = 1'b0;
                d.sda_low = d.ph[1];
            end
            ST_STOP: begin
                d.scl_low = !d.ph[1];
                if (d.ph == 2'd1) d.sda_low = 1'b1;
            end
            ST_TX: begin
                d.scl_low = !d.ph[1];
                if (d.ph == 2'd1) d.sda_low = !d.sh[7];
            end
            default: begin
                d.scl_low = !d.ph[1];
                if (d.ph == 2'd1) d.sda_low = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign scl_oe  = q.scl_low;
    assign sda_oe  = q.sda_low;
    assign rx_byte = q.sh;
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wdata,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rdata,
    input  logic        busy,
    input  logic        ev_rdone,
    input  logic        ev_nack,
    input  logic [7:0]  rx_byte,
    output logic        go,
    output logic        go_rd,
    output logic [6:0]  go_saddr,
    output logic [7:0]  go_idx,
    output logic [7:0]  go_wdat,
    output logic        done_flag,
    output logic        err_flag
);
    regs_s d, q;
    logic  cmd_wr, op_ok;

    always_comb begin
        cmd_wr   = wr && (wr_addr == RA_CMD);
        op_ok    = (wdata[15:8] == OP_WRITE) || (wdata[15:8] == OP_READ);
        go       = cmd_wr && op_ok && !busy;
        go_rd    = (wdata[15:8] == OP_READ);
        go_saddr = wdata[7:1];
        go_idx   = q.arg[7:0];
        go_wdat  = q.arg[15:8];

        d = q;
        if (wr && (wr_addr == RA_ARG)) d.arg = wdata;
        if (wr && (wr_addr == RA_STAT)) begin
            if (wdata[SB_DONE]) d.done = 1'b0;
            if (wdata[SB_ERR])  d.err  = 1'b0;
        end
        if (ev_rdone) begin
            d.done = 1'b1;
            d.res  = rx_byte;
        end
        if (ev_nack) d.err = 1'b1;

        rdata = '0;
        case (rd_addr)
            RA_STAT: begin
                rdata[SB_BUSY] = busy;
                rdata[SB_ERR]  = q.err;
                rdata[SB_DONE] = q.done;
            end
            RA_ARG:  rdata = q.arg;
            RA_RES:  rdata = {q.res, 8'h00};
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_flag = q.done;
    assign err_flag  = q.err;
endmodule

// File: rtl/i2c_mbox_master.sv
module i2c_mbox_master #(
    parameter int CLK_HZ = 100_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_wr_addr,
    input  logic [15:0] reg_wdata,
    input  logic [1:0]  reg_rd_addr,
    output logic [15:0] reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    localparam int QRAW = CLK_HZ / (4 * SCL_HZ);
    localparam int QDIV = (QRAW > 0) ? QRAW : 1;

    logic       eng_busy, qtick;
    logic       go, go_rd;
    logic [6:0] go_saddr;
    logic [7:0] go_idx, go_wdat, rx_byte;
    logic       ev_rdone, ev_nack;
    logic       done_flag, err_flag;

    i2cm_qtick #(.QDIV(QDIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .tick  (qtick)
    );

    i2cm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wr_addr   (reg_wr_addr),
        .wdata     (reg_wdata),
        .rd_addr   (reg_rd_addr),
        .rdata     (reg_rdata),
        .busy      (eng_busy),
        .ev_rdone  (ev_rdone),
        .ev_nack   (ev_nack),
        .rx_byte   (rx_byte),
        .go        (go),
        .go_rd     (go_rd),
        .go_saddr  (go_saddr),
        .go_idx    (go_idx),
        .go_wdat   (go_wdat),
        .done_flag (done_flag),
        .err_flag  (err_flag)
    );

    i2cm_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_rd    (go_rd),
        .go_saddr (go_saddr),
        .go_idx   (go_idx),
        .go_wdat  (go_wdat),
        .tick     (qtick),
        .sda_in   (sda_in),
        .busy     (eng_busy),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .ev_rdone (ev_rdone),
        .ev_nack  (ev_nack),
        .rx_byte  (rx_byte)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        ev_rdone,
    input logic        ev_nack,
    input logic        done_flag,
    input logic        err_flag,
    input logic        wr,
    input logic [1:0]  wr_addr,
    input logic [15:0] wdata
);
    logic done_clr;
    assign done_clr = wr && (wr_addr == RA_STAT) && wdata[SB_DONE];

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R10

    AST_EVENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rdone || ev_nack) |-> busy); // R4

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rdone |=> done_flag); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag); // R5

    AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !ev_rdone) |=> !done_flag); // R5

    AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (err_flag && !busy && !done_flag && $stable(done_flag))); // R7
endmodule

bind i2c_mbox_master i2cm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .ev_rdone  (ev_rdone),
    .ev_nack   (ev_nack),
    .done_flag (done_flag),
    .err_flag  (err_flag),
    .wr        (reg_wr),
    .wr_addr   (reg_wr_addr),
    .wdata     (reg_wdata)
);

// File: tb/i2c_mbox_master_bench.sv
module i2c_mbox_master_bench;
    localparam int CLK_HZ = 8_000_000;
    localparam int SCL_HZ = 1_000_000;
    localparam int QD     = CLK_HZ / (4 * SCL_HZ);
    localparam logic [6:0] SLV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wr_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [1:0]  reg_rd_addr = 2'd0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe, sda_in;

    always #5 clk = ~clk;

    i2c_mbox_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_i2c_mbox_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wr_addr (reg_wr_addr),
        .reg_wdata   (reg_wdata),
        .reg_rd_addr (reg_rd_addr),
        .reg_rdata   (reg_rdata),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .sda_in      (sda_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- open-drain slave model ----------------
    logic slv_low = 1'b0;
    wire  scl_w = ~scl_oe;
    wire  sda_w = ~(sda_oe | slv_low);
    assign sda_in = sda_w;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] smem [0:255];
    logic [15:0] exp_wr [$];   // scoreboard: {index, data}
    logic scl_p = 1'b1, sda_p = 1'b1;
    logic sack = 1'b0, start_pend = 1'b0, nack_data = 1'b0;
    int   smode = 0, sbc = 0, sbyte = 0;
    int   n_start = 0, n_stop = 0, n_low = 0;
    int   bad_low = 0, bad_start = 0, bad_stop = 0;
    int   t_fall = 0, t_rise = 0, t_sf = 0;
    logic [7:0] ssh = 8'h0, sptr = 8'h0, stx = 8'h0;

    always @(scl_w or sda_w) begin
        if (scl_w === 1'b1 && scl_p && sda_p && sda_w === 1'b0) begin
            n_start++; smode = 1; sbc = 0; sbyte = 0; sack = 0; slv_low = 0;
            t_sf = cyc; start_pend = 1;
        end else if (scl_w === 1'b1 && scl_p && !sda_p && sda_w === 1'b1) begin
            n_stop++; smode = 0; sack = 0; slv_low = 0;
            if (cyc - t_rise < 2 * QD) bad_stop++;
        end else if (scl_w === 1'b1 && scl_p === 1'b0) begin
            t_rise = cyc; n_low++;
            if (cyc - t_fall != 2 * QD) bad_low++;
            if (smode == 1 && !sack) begin
                ssh = {ssh[6:0], sda_w};
                sbc++;
            end
        end else if (scl_w === 1'b0 && scl_p === 1'b1) begin
            t_fall = cyc;
            if (start_pend) begin
                if (cyc - t_sf < 2 * QD) bad_start++;
                start_pend = 0;
            end
            if (smode == 1) begin
                if (sack) begin
                    sack = 0; slv_low = 0;
                    if (sbyte == 0) begin
                        if (ssh[0]) begin
                            smode = 2; stx = smem[sptr]; slv_low = !stx[7]; sbc = 1;
                        end else sbyte = 1;
                    end else if (sbyte == 1) begin
                        sptr = ssh; sbyte = 2;
                    end else if (!nack_data) begin
                        if (exp_wr.size() == 0) check("R2 unexpected write", {sptr, ssh}, 16'hxxxx);
                        else check("R2 slave write index/data", {sptr, ssh}, exp_wr.pop_front());
                        smem[sptr] = ssh;
                    end
                end else if (sbc == 8) begin
                    sbc = 0;
                    if (sbyte == 0 && ssh[7:1] != SLV) begin
                        smode = 0; slv_low = 0;
                    end else begin
                        sack = 1;
                        slv_low = !(sbyte == 2 && nack_data);
                    end
                end
            end else if (smode == 2) begin
                if (sbc < 8) begin
                    slv_low = !stx[7 - sbc];
                    sbc++;
                end else slv_low = 0;
            end
        end
        scl_p = scl_w;
        sda_p = sda_w;
    end

    // ---------------- host driver tasks ----------------
    task automatic host_wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wr_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 3000; i++) begin
            host_rd(2'd0, s);
            if (!s[12]) return;
        end
        check("R4 busy never cleared", 16'h1, 16'h0);
    endtask

    task automatic start_write(logic [6:0] sa, logic [7:0] idx, logic [7:0] dat, bit expect_store);
        host_wr(2'd1, {dat, idx});
        if (expect_store) exp_wr.push_back({idx, dat});
        host_wr(2'd2, 16'hC400 | {8'h00, sa, 1'b0});
    endtask

    logic [15:0] v;
    int s0, p0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) smem[i] = 8'(i ^ 8'h11);

        // R12: reset state
        host_rd(2'd0, v); check("R12 status after reset", v, 16'h0000);
        host_rd(2'd1, v); check("R12 argument after reset", v, 16'h0000);
        host_rd(2'd3, v); check("R12 result after reset", v, 16'h0000);
        check("R12 lines released", {14'h0, scl_oe, sda_oe}, 16'h0);

        // R1: argument readback
        host_wr(2'd1, 16'hA55A);
        host_rd(2'd1, v); check("R1 argument readback", v, 16'hA55A);

        // R2/R4: write transaction
        s0 = n_start; p0 = n_stop;
        start_write(SLV, 8'h03, 8'h5A, 1);
        host_rd(2'd0, v); check("R4 busy after command", v & 16'h1000, 16'h1000);
        wait_idle();
        check("R2 slave register 3", {8'h0, smem[3]}, 16'h005A);
        check("R2 one start one stop", 16'((n_start - s0) * 16 + (n_stop - p0)), 16'h0011);
        host_rd(2'd0, v); check("R4 status idle after write", v, 16'h0000);

        // R3/R6/R8: read, with a command issued mid-transfer
        smem[8'h07] = 8'hC3;
        s0 = n_start; p0 = n_stop;
        host_wr(2'd1, 16'h0007);
        host_wr(2'd2, 16'hC000 | {8'h00, SLV, 1'b0});
        repeat (40) @(negedge clk);
        host_wr(2'd2, 16'hC400 | {8'h00, SLV, 1'b0});   // R8: must be ignored
        wait_idle();
        repeat (20) @(negedge clk);
        check("R3 two starts one stop", 16'((n_start - s0) * 16 + (n_stop - p0)), 16'h0021);
        check("R8 no write from ignored command", 16'(exp_wr.size()), 16'h0);
        check("R8 slave register 7 untouched", {8'h0, smem[7]}, 16'h00C3);
        host_rd(2'd0, v); check("R5 read done set", v, 16'h4000);
        host_rd(2'd3, v); check("R6 result word", v, 16'hC300);

        // R5: write-1-to-clear
        host_wr(2'd0, 16'h0000);
        host_rd(2'd0, v); check("R5 writing 0 keeps done", v, 16'h4000);
        host_wr(2'd0, 16'h4000);
        host_rd(2'd0, v); check("R5 writing 1 clears done", v, 16'h0000);

        // R9: invalid opcode
        s0 = n_start;
        host_wr(2'd2, 16'h12A0);
        host_rd(2'd0, v); check("R9 bad opcode not busy", v, 16'h0000);
        repeat (20) @(negedge clk);
        check("R9 bus untouched", {14'h0, scl_oe, 1'b0}, 16'h0);
        check("R9 no start", 16'(n_start - s0), 16'h0);

        // R7: address NACK on a read
        p0 = n_stop;
        host_wr(2'd1, 16'h0009);
        host_wr(2'd2, 16'hC000 | {8'h00, 7'h22, 1'b0});
        wait_idle();
        host_rd(2'd0, v); check("R7 address nack flags", v, 16'h2000);
        check("R7 stop after nack", 16'(n_stop - p0), 16'h1);
        host_rd(2'd3, v); check("R7 result unchanged", v, 16'hC300);
        host_wr(2'd0, 16'h2000);
        host_rd(2'd0, v); check("R7 error cleared by 1", v, 16'h0000);

        // R7: data NACK on a write
        nack_data = 1'b1;
        start_write(SLV, 8'h05, 8'h77, 0);
        wait_idle();
        nack_data = 1'b0;
        host_rd(2'd0, v); check("R7 data nack flags", v, 16'h2000);
        check("R7 slave register 5 unchanged", {8'h0, smem[5]}, 16'h0014);
        host_wr(2'd0, 16'h6000);

        // R3/R6: read at the top index, then a second write
        smem[8'hFF] = 8'h81;
        host_wr(2'd1, 16'h00FF);
        host_wr(2'd2, 16'hC000 | {8'h00, SLV, 1'b1});   // bit 0 of the command is don't-care
        wait_idle();
        host_rd(2'd3, v); check("R6 result top index", v, 16'h8100);
        host_rd(2'd0, v); check("R5 done after second read", v, 16'h4000);
        start_write(SLV, 8'h00, 8'hFE, 1);
        wait_idle();
        check("R2 slave register 0", {8'h0, smem[0]}, 16'h00FE);
        check("R2 scoreboard drained", 16'(exp_wr.size()), 16'h0);

        // R10/R11: bus timing seen by the slave over the whole run
        check("R10 SCL low phases measured", 16'(n_low > 0), 16'h1);
        check("R10 SCL low phase length", 16'(bad_low), 16'h0);
        check("R11 start hold", 16'(bad_start), 16'h0);
        check("R11 stop setup", 16'(bad_stop), 16'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule